// File: doc/BRIEF.md
# Dual-Channel Converter Offset Calibration Controller

This block is the digital core behind a two-channel serial converter. It follows the frames on a chip-select and serial clock pair. A frame opens when chip-select falls and completes on the 19th rising edge of the serial clock. At that edge it latches one signed raw sample per channel. The block then does one of two things. In a calibration frame it stores each channel's measured code as that channel's offset, clamped to a fixed correction range. In a normal frame it emits the raw code minus the stored offset, saturated to the result width.

A calibration is requested in one of two ways. The request pin may be high when chip-select falls. Or a control-register write strobe may arm one for the next frame, which is refused while the converters are marked powered down. A frame is flagged corrupted when the request pin rises partway through it, or when the register strobe fires during it. A chip-select rise before the frame completes aborts the frame silently. The gain selection is recorded at each calibration. It never alters the stored offsets, and a status flag shows when the current gain no longer matches the one used at calibration.

Top module: `adc_offset_cal`

## Requirements
- R1: After reset, resValid, calDone, resCorrupt, gainStale, resA and resB are all zero, and both stored offsets are zero, so the first normal frame returns its raw codes unchanged.
- R2: A frame is a falling edge of csN followed by 19 rising edges of sclk with csN low. The result appears one clk cycle after the clk edge that samples the 19th sclk rise. Further sclk edges before csN rises have no effect.
- R3: A frame that opens with calPin high is a calibration frame. It raises calDone for one cycle, raises no resValid, and stores rawA and rawB as the channel A and channel B offsets.
- R4: A stored offset is clamped to the range -500 to +500. A measured code beyond the range is stored as the nearer limit.
- R5: A normal frame raises resValid for one cycle, with resA = rawA - offsetA and resB = rawB - offsetB as 14-bit two's complement.
- R6: The subtraction saturates at +8191 and -8192 instead of wrapping.
- R7: While calPin stays high over consecutive frames, every one of those frames is a calibration, and the latest one sets the offsets.
- R8: If calPin rises after csN falls and before the 19th sclk rise of a normal frame, that frame's result carries resCorrupt = 1. Otherwise resCorrupt = 0.
- R9: A calBitWr pulse with powerDown low makes the next frame a calibration, even if calPin is low. If the pulse comes during a frame before its 19th sclk rise, that frame's result is marked corrupted.
- R10: A calBitWr pulse while powerDown is high has no effect: the next frame is normal and is not marked corrupted.
- R11: A csN rise before the 19th sclk rise aborts the frame: no resValid, no calDone, and no offset change.
- R12: Changing gainSel does not alter the stored offsets. gainStale is 1 exactly when a calibration has completed and gainSel differs from its value at the latest calibration.
- R13: resValid and calDone are single-cycle pulses and never high together, and resA and resB change only in a cycle where resValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all frame inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip-select framing a conversion |
| sclk | input | 1 | Serial clock; its rising edges are counted within a frame |
| calPin | input | 1 | Calibration request level |
| calBitWr | input | 1 | One-cycle write strobe of the control-register calibration bit |
| powerDown | input | 1 | Converters marked powered down; calBitWr is ignored while high |
| gainSel | input | 3 | Current amplifier gain selection |
| rawA | input | 14 | Signed raw code of channel A, latched at frame completion |
| rawB | input | 14 | Signed raw code of channel B, latched at frame completion |
| resA | output | 14 | Offset-corrected channel A result |
| resB | output | 14 | Offset-corrected channel B result |
| resValid | output | 1 | One-cycle strobe marking a new result |
| resCorrupt | output | 1 | Corruption flag accompanying the current result |
| calDone | output | 1 | One-cycle strobe marking a completed calibration |
| gainStale | output | 1 | Gain differs from the gain at the latest calibration |

## Verification
The hardest states to reach are the interactions between requests and frame phase. Examples are a request pin that rises in the middle of a normal frame, a register write that arrives mid-frame and so corrupts the current result while arming the next frame, and an arming that survives an aborted frame. The bench reaches these with a frame task that can raise the pin, pulse the register strobe or end the frame early at any chosen sclk count. It uses this task both for directed cases and for seeded random frames, with random gain and power-down levels in the mix. The saturation corners need the clamp first: a calibration with out-of-range codes sets each offset to a limit, and extreme raw codes then follow.

// File: rtl/adcOffCal_pkg.sv
package adcOffCal_pkg;
  typedef struct packed {
    logic calLoad;
    logic resLoad;
    logic corrupt;
  } dpStrobe_t;
endpackage

// File: rtl/adcOffCalCtrl.sv
module adcOffCalCtrl
  import adcOffCal_pkg::*;
#(
  parameter int FRAME_CLKS = 19
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      calPin,
  input  logic      calBitWr,
  input  logic      powerDown,
  output dpStrobe_t strobe
);
  localparam int CNT_W = $clog2(FRAME_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_CLKS);

  logic prevCs, prevSclk, prevCal;
  logic inFrame, isCal, corruptQ, calArmed;
  logic [CNT_W-1:0] edgeCnt;

  logic csFall, csRise, sclkRise, armReq, calRise, frameOpen, frameEnd;

  always_comb begin
    csFall    = prevCs & ~csN;
    csRise    = ~prevCs & csN;
    sclkRise  = ~prevSclk & sclk;
    calRise   = calPin & ~prevCal;
    armReq    = calBitWr & ~powerDown;
    frameOpen = inFrame & (edgeCnt != FULL_CNT);
    frameEnd  = frameOpen & ~csRise & sclkRise & (edgeCnt == LAST_EDGE);
    strobe.calLoad = frameEnd & isCal;
    strobe.resLoad = frameEnd & ~isCal;
    strobe.corrupt = corruptQ | ((armReq | calRise) & frameOpen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs   <= 1'b1;
      prevSclk <= 1'b0;
      prevCal  <= 1'b0;
      inFrame  <= 1'b0;
      isCal    <= 1'b0;
      corruptQ <= 1'b0;
      calArmed <= 1'b0;
      edgeCnt  <= '0;
    end else begin
      prevCs   <= csN;
      prevSclk <= sclk;
      prevCal  <= calPin;
      if (csFall) begin
        inFrame  <= 1'b1;
        edgeCnt  <= '0;
        isCal    <= calPin | calArmed;
        calArmed <= armReq;
        corruptQ <= armReq;
      end else begin
        if (armReq) calArmed <= 1'b1;
        if (inFrame) begin
          if (csRise) begin
            inFrame <= 1'b0;
          end else if (frameOpen) begin
            if (sclkRise) edgeCnt <= edgeCnt + 1'b1;
            if (armReq | calRise) corruptQ <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adcOffCalDatapath.sv
module adcOffCalDatapath
  import adcOffCal_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int OFF_LIM = 500,
  parameter int NCH     = 2,
  parameter int GAIN_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic [GAIN_W-1:0]        gainSel,
  input  logic signed [DATA_W-1:0] raw [NCH],
  output logic signed [DATA_W-1:0] res [NCH],
  output logic signed [DATA_W-1:0] off [NCH],
  output logic                     resValid,
  output logic                     resCorrupt,
  output logic                     calDone,
  output logic                     gainStale
);
  localparam logic signed [DATA_W:0]   SAT_HI = {2'b00, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W:0]   SAT_LO = {2'b11, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] LIM_HI = DATA_W'(OFF_LIM);
  localparam logic signed [DATA_W-1:0] LIM_LO = -LIM_HI;

  logic [GAIN_W-1:0] gainAtCal;
  logic              calibrated;

  for (genvar ch = 0; ch < NCH; ch++) begin : gLane
    logic signed [DATA_W:0]   diff;
    logic signed [DATA_W-1:0] satDiff, clampRaw;

    always_comb begin
      diff = {raw[ch][DATA_W-1], raw[ch]} - {off[ch][DATA_W-1], off[ch]};
      if (diff > SAT_HI)      satDiff = SAT_HI[DATA_W-1:0];
      else if (diff < SAT_LO) satDiff = SAT_LO[DATA_W-1:0];
      else                    satDiff = diff[DATA_W-1:0];
      if (raw[ch] > LIM_HI)      clampRaw = LIM_HI;
      else if (raw[ch] < LIM_LO) clampRaw = LIM_LO;
      else                       clampRaw = raw[ch];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        off[ch] <= '0;
        res[ch] <= '0;
      end else begin
        if (strobe.calLoad) off[ch] <= clampRaw;
        if (strobe.resLoad) res[ch] <= satDiff;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resCorrupt <= 1'b0;
      calDone    <= 1'b0;
      gainAtCal  <= '0;
      calibrated <= 1'b0;
    end else begin
      resValid <= strobe.resLoad;
      calDone  <= strobe.calLoad;
      if (strobe.resLoad) resCorrupt <= strobe.corrupt;
      if (strobe.calLoad) begin
        gainAtCal  <= gainSel;
        calibrated <= 1'b1;
      end
    end
  end

  assign gainStale = calibrated & (gainSel != gainAtCal);
endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal
  import adcOffCal_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int OFF_LIM    = 500,
  parameter int FRAME_CLKS = 19,
  parameter int GAIN_W     = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sclk,
  input  logic                     calPin,
  input  logic                     calBitWr,
  input  logic                     powerDown,
  input  logic [GAIN_W-1:0]        gainSel,
  input  logic signed [DATA_W-1:0] rawA,
  input  logic signed [DATA_W-1:0] rawB,
  output logic signed [DATA_W-1:0] resA,
  output logic signed [DATA_W-1:0] resB,
  output logic                     resValid,
  output logic                     resCorrupt,
  output logic                     calDone,
  output logic                     gainStale
);
  localparam int NCH = 2;

  dpStrobe_t                strobe;
  logic signed [DATA_W-1:0] rawVec [NCH];
  logic signed [DATA_W-1:0] resVec [NCH];
  logic signed [DATA_W-1:0] offVec [NCH];

  assign rawVec[0] = rawA;
  assign rawVec[1] = rawB;
  assign resA = resVec[0];
  assign resB = resVec[1];

  adcOffCalCtrl #(.FRAME_CLKS(FRAME_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .calPin(calPin),
    .calBitWr(calBitWr), .powerDown(powerDown), .strobe(strobe)
  );

  adcOffCalDatapath #(
    .DATA_W(DATA_W), .OFF_LIM(OFF_LIM), .NCH(NCH), .GAIN_W(GAIN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .gainSel(gainSel),
    .raw(rawVec), .res(resVec), .off(offVec), .resValid(resValid),
    .resCorrupt(resCorrupt), .calDone(calDone), .gainStale(gainStale)
  );
endmodule

// File: rtl/adcOffCalChecker.sv
module adcOffCalChecker #(
  parameter int DATA_W  = 14,
  parameter int OFF_LIM = 500
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     csN,
  input logic                     sclk,
  input logic                     resValid,
  input logic                     calDone,
  input logic signed [DATA_W-1:0] resA,
  input logic signed [DATA_W-1:0] resB,
  input logic signed [DATA_W-1:0] offA,
  input logic signed [DATA_W-1:0] offB
);
  localparam logic signed [DATA_W-1:0] LIM = DATA_W'(OFF_LIM);

  assert_strobe_exclusive_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && calDone));

  assert_valid_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_cal_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    calDone |=> !calDone);

  assert_frame_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    (resValid || calDone) |-> ($past(sclk) && !$past(csN)));

  assert_offset_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (offA <= LIM) && (offA >= -LIM) && (offB <= LIM) && (offB >= -LIM));

  assert_result_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> ($stable(resA) && $stable(resB)));
endmodule

bind adc_offset_cal adcOffCalChecker #(.DATA_W(DATA_W), .OFF_LIM(OFF_LIM)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .resValid(resValid),
  .calDone(calDone), .resA(resA), .resB(resB),
  .offA(offVec[0]), .offB(offVec[1])
);

// File: tb/sim_adc_offset_cal.sv
module sim_adc_offset_cal;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, csN, sclk, calPin, calBitWr, powerDown;
  logic [2:0] gainSel;
  logic signed [13:0] rawA, rawB, resA, resB;
  logic resValid, resCorrupt, calDone, gainStale;

  adc_offset_cal u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .calPin(calPin),
    .calBitWr(calBitWr), .powerDown(powerDown), .gainSel(gainSel),
    .rawA(rawA), .rawB(rawB), .resA(resA), .resB(resB), .resValid(resValid),
    .resCorrupt(resCorrupt), .calDone(calDone), .gainStale(gainStale)
  );

  int total = 0, bad = 0;
  int nValid = 0, nCal = 0;
  logic signed [13:0] gotA = '0, gotB = '0;
  logic gotC = 1'b0;

  int mOffA = 0, mOffB = 0;
  bit mArm = 0, mCalib = 0;
  logic [2:0] mGainCal = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (resValid) begin
        nValid++;
        gotA = resA;
        gotB = resB;
        gotC = resCorrupt;
      end
      if (calDone) nCal++;
    end
  end

  function automatic int clampM(int v);
    if (v > 500) return 500;
    if (v < -500) return -500;
    return v;
  endfunction

  function automatic int satM(int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic runFrame(string tag, int rA, int rB, bit calLvl, int nClk,
                          int riseAt, int wrAt);
    int v0, c0;
    bit isCal, corr;
    v0 = nValid;
    c0 = nCal;
    @(negedge clk);
    calPin = calLvl;
    rawA = 14'(rA);
    rawB = 14'(rB);
    @(negedge clk);
    csN = 1'b0;
    isCal = calLvl | mArm;
    mArm = 0;
    corr = 0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 1; i <= nClk; i++) begin
      if (i == riseAt) begin
        calPin = 1'b1;
        if (i <= 19 && !calLvl) corr = 1;
      end
      if (i == wrAt) begin
        calBitWr = 1'b1;
        if (!powerDown) begin
          mArm = 1;
          if (i <= 19) corr = 1;
        end
      end
      sclk = 1'b1;
      @(negedge clk);
      calBitWr = 1'b0;
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    csN = 1'b1;
    repeat (3) @(negedge clk);
    if (nClk >= 19 && isCal) begin
      mOffA = clampM(rA);
      mOffB = clampM(rB);
      mCalib = 1;
      mGainCal = gainSel;
      chk({tag, " cal strobe R3"}, nCal, c0 + 1);
      chk({tag, " no valid in cal R3"}, nValid, v0);
    end else if (nClk >= 19) begin
      chk({tag, " valid strobe R2"}, nValid, v0 + 1);
      chk({tag, " no cal R2"}, nCal, c0);
      chk({tag, " resA R5"}, int'(gotA), satM(rA - mOffA));
      chk({tag, " resB R5"}, int'(gotB), satM(rB - mOffB));
      chk({tag, " corrupt R8"}, int'(gotC), int'(corr));
    end else begin
      chk({tag, " abort valid R11"}, nValid, v0);
      chk({tag, " abort cal R11"}, nCal, c0);
    end
    chk({tag, " gainStale R12"}, int'(gainStale),
        int'(mCalib && (gainSel != mGainCal)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R2 actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7315));
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; calPin = 1'b0; calBitWr = 1'b0;
    powerDown = 1'b0; gainSel = '0; rawA = '0; rawB = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("reset resValid R1", int'(resValid), 0);
    chk("reset calDone R1", int'(calDone), 0);
    chk("reset resA R1", int'(resA), 0);
    chk("reset resB R1", int'(resB), 0);
    chk("reset corrupt R1", int'(resCorrupt), 0);
    chk("reset gainStale R1", int'(gainStale), 0);
    runFrame("R1 zero offset", 1234, -4321, 0, 19, -1, -1);
    // R2 extra sclk edges ignored
    runFrame("R2 extra edges", 77, -88, 0, 24, -1, -1);
    // R3 calibration then normal
    runFrame("R3 cal", 123, -77, 1, 19, -1, -1);
    runFrame("R5 after cal", 1000, -1000, 0, 19, -1, -1);
    // R7 pin held over frames
    runFrame("R7 cal one", 10, 20, 1, 19, -1, -1);
    runFrame("R7 cal two", -30, 40, 1, 19, -1, -1);
    runFrame("R7 normal", 500, 500, 0, 19, -1, -1);
    // R4 clamp then R6 saturation
    runFrame("R4 clamp cal", -1000, 900, 1, 19, -1, -1);
    runFrame("R6 sat", -8000, 8000, 0, 19, -1, -1);
    runFrame("R6 extremes", 8191, -8192, 0, 19, -1, -1);
    // R8 mid-frame pin rise
    runFrame("R8 pin rise", 300, -300, 0, 19, 7, -1);
    calPin = 1'b0;
    runFrame("R8 next clean", 300, -300, 0, 19, -1, -1);
    // R9 register bit mid-frame
    runFrame("R9 reg write", 50, 60, 0, 19, -1, 5);
    runFrame("R9 armed cal", 222, -111, 0, 19, -1, -1);
    runFrame("R9 check", 0, 0, 0, 19, -1, -1);
    // R10 power down ignores bit
    powerDown = 1'b1;
    runFrame("R10 pd write", 45, 46, 0, 19, -1, 6);
    runFrame("R10 pd next", 45, 46, 0, 19, -1, -1);
    powerDown = 1'b0;
    // R11 abort keeps offsets
    runFrame("R11 abort cal", 400, 400, 1, 12, -1, -1);
    runFrame("R11 after abort", 400, 400, 0, 19, -1, -1);
    // R12 gain change keeps offsets
    gainSel = 3'd5;
    runFrame("R12 gain change", -2000, 2000, 0, 19, -1, -1);
    gainSel = 3'd0;
    // random frames
    for (int n = 0; n < 40; n++) begin
      int rA, rB, nc, ra, wa;
      bit cl;
      rA = int'($urandom_range(0, 16383)) - 8192;
      rB = int'($urandom_range(0, 16383)) - 8192;
      cl = ($urandom_range(0, 4) == 0);
      if (cl && $urandom_range(0, 1) == 1) begin
        rA = int'($urandom_range(0, 1400)) - 700;
        rB = int'($urandom_range(0, 1400)) - 700;
      end
      case ($urandom_range(0, 5))
        0: nc = int'($urandom_range(3, 18));
        1: nc = 22;
        default: nc = 19;
      endcase
      ra = (!cl && $urandom_range(0, 7) == 0) ? int'($urandom_range(2, 18)) : -1;
      wa = ($urandom_range(0, 7) == 0) ? int'($urandom_range(2, 18)) : -1;
      powerDown = ($urandom_range(0, 3) == 0);
      gainSel = 3'($urandom_range(0, 7));
      runFrame("R5 random", rA, rB, cl, nc, ra, wa);
      calPin = 1'b0;
    end
    summary();
    $finish;
  end
endmodule